// File: doc/BRIEF.md
# Power-On Strap Configuration Register

This block sets the clock-source and pin-mode choices of a chip from levels that the board places on part of the shared memory data bus while reset is held. For as long as reset is asserted, the block loads the strap lines on every clock. When reset is released it keeps the last value it loaded. That value becomes the register content that drives five controls:

- the direction of the dot clock pin;
- the enable of the memory clock output;
- the direction of the host clock pin;
- the divide ratio chosen for the PCI clock;
- whether a group of shared pins serves as a test bus or as normal IOs.

After reset, software reaches the register through an 8-bit indexed port. A write strobe loads the index, a second write strobe stores data at that index, and a read strobe returns the indexed register one clock later. Software can therefore override the board's choices. The level of one extra strap line, data line 23, is held in a flag that is kept apart from the register and cannot be written.

The strap input bus `strap_lines` carries six lines. Bits [4:0] are memory data lines 20 down to 16, and bit [5] is memory data line 23.

Top module: `strap_cfg_top`

## Requirements
- R1: On every clock edge where `rst` is high, the strap register loads `strap_lines[4:0]`. At the first edge with `rst` low it holds the value loaded at the last reset edge.
- R2: `aux_strap_flag` loads `strap_lines[5]` on every reset edge, keeps its value while `rst` is low, and no port write changes it.
- R3: `dclk_drive` equals register bit 4. A 1 means the dot clock pin is driven by the internal synthesizer, and a 0 means the pin is an input.
- R4: `mclk_drive` equals register bit 3. A 1 means the memory clock output is driven by the synthesizer, and a 0 means it is tristated.
- R5: `hclk_drive` equals register bit 2. A 1 means the host clock pin is an output, and a 0 means it is an input.
- R6: `pci_div2_sel` equals register bit 1. A 1 selects the host clock divided by 2, and a 0 selects the host clock divided by 3.
- R7: `io_normal_sel` equals register bit 0. A 1 selects normal IOs, and a 0 selects the test bus.
- R8: When `cfg_idx_we` is high at an edge, the index loads `cfg_wdata`. When `cfg_dat_we` is high and the index (its value before that edge) is 8'h4C, register bits 4:0 load `cfg_wdata[4:0]`, and the outputs show the new value after that same edge.
- R9: When `cfg_dat_re` is high at an edge, `cfg_rdata` loads the indexed register as it stood before the edge. Index 8'h4C reads as {3'b000, bits 4:0}. Otherwise `cfg_rdata` holds its value.
- R10: Reads of indices 8'h4A, 8'h4B and every other index except 8'h4C return 8'h00. Data writes to them change nothing. Bits 7:5 of index 8'h4C always read 0.
- R11: While `rst` is high, the index resets to 8'h00, `cfg_rdata` resets to 8'h00, and index, data and read strobes have no effect.
- R12: Once `rst` is low, changes on `strap_lines` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are loaded while it is high |
| strap_lines | input | 6 | [4:0] = data lines 20..16, [5] = data line 23 |
| cfg_idx_we | input | 1 | Index write strobe |
| cfg_dat_we | input | 1 | Data write strobe |
| cfg_dat_re | input | 1 | Data read strobe |
| cfg_wdata | input | 8 | Index or data write value |
| cfg_rdata | output | 8 | Registered read data |
| aux_strap_flag | output | 1 | Read-only flag holding data line 23 |
| dclk_drive | output | 1 | Dot clock pin is an output driven by the synthesizer |
| mclk_drive | output | 1 | Memory clock output is enabled; 0 means tristated |
| hclk_drive | output | 1 | Host clock pin is an output driven by the synthesizer |
| pci_div2_sel | output | 1 | 1: PCI clock is the host clock / 2; 0: host clock / 3 |
| io_normal_sel | output | 1 | 1: shared pins are normal IOs; 0: test bus |

## Verification
The bench changes the strap lines on several edges during reset. A design that loaded only once, or that kept loading after reset, would show the wrong clock-pin modes when reset is released or later.

It writes all ones to the strap index and to the reserved indices. A design that let bits 7:5 through, or that decoded the reserved indices as live, would return nonzero read data.

It strobes an index write and a data write in the same cycle, which catches a design that uses the new index instead of the old one. It also writes during reset, which catches a design that lets that write beat the strap load.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

    localparam int unsigned REG_W     = 8;
    localparam int unsigned STRAP_W   = 5;
    localparam int unsigned LINES_W   = STRAP_W + 1;
    localparam int unsigned AUX_POS   = STRAP_W;
    localparam logic [REG_W-1:0] IDX_RSV_A = 8'h4A;
    localparam logic [REG_W-1:0] IDX_RSV_B = 8'h4B;
    localparam logic [REG_W-1:0] IDX_STRAP = 8'h4C;

    // Bit order matters: bit 4 dot clock ... bit 0 IO mode.
    typedef struct packed {
        logic dot_int;
        logic mem_int;
        logic host_int;
        logic pci_half;
        logic io_user;
    } strap_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_RSV   = 2'd1,
        SEL_STRAP = 2'd2
    } idx_sel_e;

    typedef enum logic {
        PCI_DIV3 = 1'b0,
        PCI_DIV2 = 1'b1
    } pci_div_e;

    function automatic idx_sel_e decode_idx(input logic [REG_W-1:0] idx);
        if (idx == IDX_STRAP)
            return SEL_STRAP;
        else if (idx == IDX_RSV_A || idx == IDX_RSV_B)
            return SEL_RSV;
        else
            return SEL_NONE;
    endfunction

    function automatic logic [REG_W-1:0] reg_view(input strap_t s);
        logic [REG_W-1:0] v;
        v = '0;
        v[STRAP_W-1:0] = s;
        return v;
    endfunction

endpackage

// File: rtl/strap_sampler.sv
module strap_sampler
    import strap_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [LINES_W-1:0] lines,
    output strap_t             sample,
    output logic               aux_q
);

    assign sample = strap_t'(lines[STRAP_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst)
            aux_q <= lines[AUX_POS];
    end

    // R2: the flag never moves outside reset
    a_r2_aux_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(aux_q));

endmodule

// File: rtl/strap_cfg_port.sv
module strap_cfg_port
    import strap_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  strap_t           sample,
    input  logic             idx_we,
    input  logic             dat_we,
    input  logic             dat_re,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output strap_t           strap_q
);

    logic [REG_W-1:0] idx_q;
    idx_sel_e         sel;
    logic             wr_strap;
    logic [REG_W-1:0] rd_mux;

    assign sel      = decode_idx(idx_q);
    assign wr_strap = dat_we && !rst && (sel == SEL_STRAP);

    always_comb begin
        unique case (sel)
            SEL_STRAP: rd_mux = reg_view(strap_q);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            rdata   <= '0;
            strap_q <= sample;
        end else begin
            if (idx_we)
                idx_q <= wdata;
            if (dat_re)
                rdata <= rd_mux;
            if (wr_strap)
                strap_q <= strap_t'(wdata[STRAP_W-1:0]);
        end
    end

    // R1: value held on release equals the lines at the last reset edge
    a_r1_capture_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> strap_q == $past(sample));

    // R8: a strap write lands on the next edge
    a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(wr_strap) |-> strap_q == strap_t'($past(wdata[STRAP_W-1:0])));

    // R12: without a write the register does not move after reset
    a_r12_no_drift: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(wr_strap) |-> $stable(strap_q));

    // R10: reads away from the strap index return zero
    a_r10_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(dat_re) && $past(sel) != SEL_STRAP |-> rdata == '0);

endmodule

// File: rtl/strap_clk_ctrl.sv
module strap_clk_ctrl
    import strap_cfg_pkg::*;
(
    input  strap_t strap_q,
    output logic   dclk_drive,
    output logic   mclk_drive,
    output logic   hclk_drive,
    output logic   pci_div2_sel,
    output logic   io_normal_sel
);

    pci_div_e pci_div;

    assign pci_div       = strap_q.pci_half ? PCI_DIV2 : PCI_DIV3;
    assign dclk_drive    = strap_q.dot_int;
    assign mclk_drive    = strap_q.mem_int;
    assign hclk_drive    = strap_q.host_int;
    assign pci_div2_sel  = (pci_div == PCI_DIV2);
    assign io_normal_sel = strap_q.io_user;

endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
    import strap_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [LINES_W-1:0] strap_lines,
    input  logic               cfg_idx_we,
    input  logic               cfg_dat_we,
    input  logic               cfg_dat_re,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    output logic               aux_strap_flag,
    output logic               dclk_drive,
    output logic               mclk_drive,
    output logic               hclk_drive,
    output logic               pci_div2_sel,
    output logic               io_normal_sel
);

    strap_t sample;
    strap_t strap_q;

    strap_sampler u_sampler (
        .clk    (clk),
        .rst    (rst),
        .lines  (strap_lines),
        .sample (sample),
        .aux_q  (aux_strap_flag)
    );

    strap_cfg_port u_port (
        .clk     (clk),
        .rst     (rst),
        .sample  (sample),
        .idx_we  (cfg_idx_we),
        .dat_we  (cfg_dat_we),
        .dat_re  (cfg_dat_re),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .strap_q (strap_q)
    );

    strap_clk_ctrl u_ctrl (
        .strap_q       (strap_q),
        .dclk_drive    (dclk_drive),
        .mclk_drive    (mclk_drive),
        .hclk_drive    (hclk_drive),
        .pci_div2_sel  (pci_div2_sel),
        .io_normal_sel (io_normal_sel)
    );

    // R11: read data is cleared by reset
    a_r11_rdata_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cfg_rdata == '0);

endmodule

// File: tb/strap_cfg_top_test.sv
module strap_cfg_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] strap_lines = 6'd0;
    logic       cfg_idx_we = 1'b0;
    logic       cfg_dat_we = 1'b0;
    logic       cfg_dat_re = 1'b0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] cfg_rdata;
    logic       aux_strap_flag, dclk_drive, mclk_drive, hclk_drive, pci_div2_sel, io_normal_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [4:0] m_bits  = '0;
    logic       m_flag  = 1'b0;
    logic [7:0] m_idx   = '0;
    logic [7:0] m_rdata = '0;
    bit         m_valid = 1'b0;

    always #5 clk = ~clk;

    strap_cfg_top uut (
        .clk(clk), .rst(rst), .strap_lines(strap_lines),
        .cfg_idx_we(cfg_idx_we), .cfg_dat_we(cfg_dat_we), .cfg_dat_re(cfg_dat_re),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .aux_strap_flag(aux_strap_flag),
        .dclk_drive(dclk_drive), .mclk_drive(mclk_drive), .hclk_drive(hclk_drive),
        .pci_div2_sel(pci_div2_sel), .io_normal_sel(io_normal_sel)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_bits  = strap_lines[4:0];
            m_flag  = strap_lines[5];
            m_idx   = 8'h00;
            m_rdata = 8'h00;
        end else begin
            if (cfg_dat_re)
                m_rdata = (m_idx == 8'h4C) ? {3'b000, m_bits} : 8'h00;
            if (cfg_dat_we && m_idx == 8'h4C)
                m_bits = cfg_wdata[4:0];
            if (cfg_idx_we)
                m_idx = cfg_wdata;
        end
        m_valid = 1'b1;
    end

    always @(negedge clk) begin
        if (m_valid && !done) begin
            check("R3 dclk_drive",    {7'd0, dclk_drive},    {7'd0, m_bits[4]});
            check("R4 mclk_drive",    {7'd0, mclk_drive},    {7'd0, m_bits[3]});
            check("R5 hclk_drive",    {7'd0, hclk_drive},    {7'd0, m_bits[2]});
            check("R6 pci_div2_sel",  {7'd0, pci_div2_sel},  {7'd0, m_bits[1]});
            check("R7 io_normal_sel", {7'd0, io_normal_sel}, {7'd0, m_bits[0]});
            check("R2 aux_strap_flag",{7'd0, aux_strap_flag},{7'd0, m_flag});
            check("R9 cfg_rdata",     cfg_rdata,             m_rdata);
        end
    end

    function automatic logic [7:0] outs();
        return {3'b000, dclk_drive, mclk_drive, hclk_drive, pci_div2_sel, io_normal_sel};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_idx_we = 0; cfg_dat_we = 0; cfg_dat_re = 0;
    endtask

    task automatic set_idx(input logic [7:0] i);
        cfg_idx_we = 1; cfg_wdata = i; tick(); idle();
    endtask

    task automatic wr_dat(input logic [7:0] d);
        cfg_dat_we = 1; cfg_wdata = d; tick(); idle();
    endtask

    task automatic rd_dat();
        cfg_dat_re = 1; tick(); idle();
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // reset with changing strap lines
        strap_lines = 6'b0_01001; tick();
        check("R11 rdata in reset", cfg_rdata, 8'h00);
        strap_lines = 6'b1_11111; tick();
        strap_lines = 6'b1_10110; tick();
        rst = 0;
        strap_lines = 6'b0_01001; tick();
        check("R1 held strap value", outs(), 8'h16);
        check("R2 flag held", {7'd0, aux_strap_flag}, 8'h01);
        tick(); tick();
        check("R12 strap change ignored", outs(), 8'h16);

        set_idx(8'h4C); tick();
        rd_dat(); check("R9 read strap", cfg_rdata, 8'h16);
        wr_dat(8'hFF);
        check("R8 write all ones", outs(), 8'h1F);
        rd_dat(); check("R10 bits 7:5 zero", cfg_rdata, 8'h1F);
        check("R2 flag unaffected by write", {7'd0, aux_strap_flag}, 8'h01);
        wr_dat(8'h00); check("R8 write zero", outs(), 8'h00);
        wr_dat(8'h15); check("R8 write 15", outs(), 8'h15);
        rd_dat(); check("R9 read 15", cfg_rdata, 8'h15);

        set_idx(8'h4A); wr_dat(8'hFF);
        check("R10 write 4A ignored", outs(), 8'h15);
        rd_dat(); check("R10 read 4A", cfg_rdata, 8'h00);
        set_idx(8'h4B); wr_dat(8'hFF); rd_dat();
        check("R10 read 4B", cfg_rdata, 8'h00);
        set_idx(8'h10); wr_dat(8'h0A); rd_dat();
        check("R10 other index", cfg_rdata, 8'h00);
        check("R10 other write ignored", outs(), 8'h15);

        // same-cycle index and data write: data uses old index 8'h10
        cfg_idx_we = 1; cfg_dat_we = 1; cfg_wdata = 8'h4C; tick(); idle();
        check("R8 old index used", outs(), 8'h15);
        wr_dat(8'h0B); check("R8 write after index", outs(), 8'h0B);
        cfg_dat_we = 1; cfg_idx_we = 1; cfg_wdata = 8'h4A; tick(); idle();
        check("R8 write with index change", outs(), 8'h0A);

        // second reset with strobes active
        rst = 1; strap_lines = 6'b0_01001;
        cfg_idx_we = 1; cfg_dat_we = 1; cfg_dat_re = 1; cfg_wdata = 8'h4C;
        tick(); tick();
        check("R11 write ignored in reset", outs(), 8'h09);
        check("R11 rdata zero in reset", cfg_rdata, 8'h00);
        idle(); rst = 0; strap_lines = 6'b1_10110; tick();
        check("R1 second capture", outs(), 8'h09);
        check("R2 second flag", {7'd0, aux_strap_flag}, 8'h00);
        wr_dat(8'h1F);
        check("R11 index reset to 00", outs(), 8'h09);
        rd_dat(); check("R11 read index 00", cfg_rdata, 8'h00);
        tick(); tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule